// File: doc/BRIEF.md
# Debug Receive Mailbox with Privilege-Gated Reads

An external debug host deposits 32-bit words into this mailbox through a simple valid/data write port. A flag records whether a word is waiting to be read. The processor side reads the word through a system-register access port. Before any data goes back, each read request is screened by a priority-ordered permission tree. That tree looks at the current privilege level (0 to 3) and at whether levels 2 and 3 are present or enabled. It also looks at which levels run the legacy 32-bit mode and at a handful of trap-control bits.

The screening decides one outcome. The read may return the word, trap to a higher level in the 64-bit style, take a hypervisor-style trap, or be reported as undefined. The outcome, target level and syndrome code come back as a registered response one clock after the request. Only a read that returns data consumes the word and clears the flag.

Top module: `dbg_rx_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, `full` is 0 and `rsp_vld` is 0 until the first read request.
- R2: A host write (`host_wr_vld`=1) stores `host_wr_data` and sets `full` at the next clock edge. When several writes arrive before a read, a successful read returns the most recent one.
- R3: A read whose outcome is data clears `full` at the same edge that registers the response. A data read with `full`=0 leaves `full` at 0.
- R4: When a host write and a flag-clearing read happen in the same cycle, `full` stays 1. That response carries the previously stored word, and the next read returns the newly written word.
- R5: At level 0 with level 1 in 64-bit mode and its user channel trap bit set, the read traps with `rsp_kind`=1 and code 0x05. The target is level 2 when level 2 is enabled in 64-bit mode with its route-all bit set; otherwise the target is level 1.
- R6: At level 0 with level 1 in 32-bit mode and its user channel disable bit set, the outcome depends on level 2. Level 2 enabled in 64-bit mode with route-all set gives kind 1, level 2, code 0x05. Level 2 enabled in 32-bit mode with route-all set gives kind 2, level 2, code 0x00. Any other case gives kind 3 (undefined), level 1, code 0x00.
- R7: At level 0, once the checks of R5 and R6 pass, a read traps with kind 1, level 2, code 0x05 when level 2 is enabled in 64-bit mode and any of route-all, debug-exception trap or debug-access trap is set.
- R8: At level 1, when level 2 is enabled and either of its debug-exception trap or debug-access trap bits is set, the read traps to level 2 with code 0x05. The kind is 1 if level 2 runs 64-bit and 2 if it runs 32-bit.
- R9: At levels 0, 1 and 2, the lowest-priority check traps to level 3 with kind 1 and code 0x05. It fires when level 3 is present, runs 64-bit, and has its debug-access trap bit set. Reads at level 3 always return data.
- R10: A read with kind 1, 2 or 3 leaves `full` unchanged and returns `rsp_data`=0.
- R11: `rsp_vld` is 1 exactly one cycle after a cycle with `rd_req`=1, and 0 otherwise. Kind encoding: 0 data, 1 trap, 2 hypervisor trap, 3 undefined. A data response reports the current level as target and code 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_vld | input | 1 | Debug host write strobe |
| host_wr_data | input | 32 | Debug host write word |
| rd_req | input | 1 | Processor read request |
| cur_lvl | input | 2 | Current privilege level of the request |
| l2_en | input | 1 | Level 2 is enabled |
| l3_have | input | 1 | Level 3 is implemented |
| l1_is32 | input | 1 | Level 1 runs 32-bit mode |
| l2_is32 | input | 1 | Level 2 runs 32-bit mode |
| l3_is32 | input | 1 | Level 3 runs 32-bit mode |
| l1_chan_trap | input | 1 | Level-1 user channel trap bit (64-bit level 1) |
| l1_chan_dis | input | 1 | Level-1 user channel disable bit (32-bit level 1) |
| l2_route_all | input | 1 | Level-2 route-all-exceptions bit |
| l2_dbg_exc_trap | input | 1 | Level-2 debug-exception trap bit |
| l2_dbg_acc_trap | input | 1 | Level-2 debug-access trap bit |
| l3_dbg_acc_trap | input | 1 | Level-3 debug-access trap bit |
| full | output | 1 | Unread word present |
| rsp_vld | output | 1 | Response valid |
| rsp_kind | output | 2 | Outcome: 0 data, 1 trap, 2 hypervisor trap, 3 undefined |
| rsp_lvl | output | 2 | Target level of the outcome |
| rsp_code | output | 6 | Syndrome code |
| rsp_data | output | 32 | Returned word, 0 unless outcome is data |

## Verification
The bench builds the block with its default 32-bit data word and 6-bit syndrome. The gating tree has only four levels and eleven control bits, so every combination is reachable: the bench sweeps all 8192 pairs of level and control setting. Each pair is preceded by a distinct host write, which exercises both the data path and the flag retention on trapped reads across the whole space. Directed sequences then cover back-to-back writes, reads of an empty mailbox, and a write that collides with a clearing read.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;

  localparam int LVL_W  = 2;
  localparam int SYND_W = 6;

  localparam logic [SYND_W-1:0] SYND_NONE     = 6'h00;
  localparam logic [SYND_W-1:0] SYND_DBG_TRAP = 6'h05;
  localparam logic [SYND_W-1:0] SYND_HYP_USER = 6'h00;

  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_TRAP  = 2'd1,
    RSP_HYP   = 2'd2,
    RSP_UNDEF = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic l2_en;
    logic l3_have;
    logic l1_is32;
    logic l2_is32;
    logic l3_is32;
    logic l1_chan_trap;
    logic l1_chan_dis;
    logic l2_route_all;
    logic l2_dbg_exc_trap;
    logic l2_dbg_acc_trap;
    logic l3_dbg_acc_trap;
  } gate_cfg_t;

  typedef struct packed {
    rsp_kind_e         kind;
    logic [LVL_W-1:0]  lvl;
    logic [SYND_W-1:0] code;
  } gate_res_t;

endpackage

// File: rtl/dbg_rx_store.sv
module dbg_rx_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clear,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q
);

  logic full_d;

  // Host write has priority over a consuming read in the same cycle.
  always_comb begin
    full_d = full_q;
    if (wr_vld) begin
      full_d = 1'b1;
    end else if (rd_clear) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  // Word register: no reset, content unspecified until first write.
  always_ff @(posedge clk) begin
    if (wr_vld) begin
      data_q <= wr_data;
    end
  end

endmodule

// File: rtl/dbg_rx_gate.sv
module dbg_rx_gate
  import dbg_rx_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl,
  input  gate_cfg_t        cfg,
  output gate_res_t        res
);

  logic l2_a64;
  logic l2_a32;
  logic l3_a64;
  logic l2_dbg_any;
  logic l3_blocks;

  always_comb begin
    l2_a64     = cfg.l2_en && !cfg.l2_is32;
    l2_a32     = cfg.l2_en &&  cfg.l2_is32;
    l3_a64     = cfg.l3_have && !cfg.l3_is32;
    l2_dbg_any = cfg.l2_dbg_exc_trap || cfg.l2_dbg_acc_trap;
    l3_blocks  = l3_a64 && cfg.l3_dbg_acc_trap;
  end

  always_comb begin
    res.kind = RSP_DATA;
    res.lvl  = cur_lvl;
    res.code = SYND_NONE;
    unique case (cur_lvl)
      2'd0: begin
        if (!cfg.l1_is32 && cfg.l1_chan_trap) begin
          res.kind = RSP_TRAP;
          res.lvl  = (l2_a64 && cfg.l2_route_all) ? 2'd2 : 2'd1;
          res.code = SYND_DBG_TRAP;
        end else if (cfg.l1_is32 && cfg.l1_chan_dis) begin
          if (l2_a64 && cfg.l2_route_all) begin
            res.kind = RSP_TRAP;
            res.lvl  = 2'd2;
            res.code = SYND_DBG_TRAP;
          end else if (l2_a32 && cfg.l2_route_all) begin
            res.kind = RSP_HYP;
            res.lvl  = 2'd2;
            res.code = SYND_HYP_USER;
          end else begin
            res.kind = RSP_UNDEF;
            res.lvl  = 2'd1;
            res.code = SYND_NONE;
          end
        end else if (l2_a64 && (cfg.l2_route_all || l2_dbg_any)) begin
          res.kind = RSP_TRAP;
          res.lvl  = 2'd2;
          res.code = SYND_DBG_TRAP;
        end else if (l3_blocks) begin
          res.kind = RSP_TRAP;
          res.lvl  = 2'd3;
          res.code = SYND_DBG_TRAP;
        end
      end
      2'd1: begin
        if (l2_a64 && l2_dbg_any) begin
          res.kind = RSP_TRAP;
          res.lvl  = 2'd2;
          res.code = SYND_DBG_TRAP;
        end else if (l2_a32 && l2_dbg_any) begin
          res.kind = RSP_HYP;
          res.lvl  = 2'd2;
          res.code = SYND_DBG_TRAP;
        end else if (l3_blocks) begin
          res.kind = RSP_TRAP;
          res.lvl  = 2'd3;
          res.code = SYND_DBG_TRAP;
        end
      end
      2'd2: begin
        if (l3_blocks) begin
          res.kind = RSP_TRAP;
          res.lvl  = 2'd3;
          res.code = SYND_DBG_TRAP;
        end
      end
      default: begin
        res.kind = RSP_DATA;
      end
    endcase
  end

endmodule

// File: rtl/dbg_rx_resp.sv
module dbg_rx_resp
  import dbg_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  gate_res_t         res_in,
  input  logic [DATA_W-1:0] word_in,
  output logic              vld_q,
  output gate_res_t         res_q,
  output logic [DATA_W-1:0] data_q
);

  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = (res_in.kind == RSP_DATA) ? word_in : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q.kind <= RSP_DATA;
      res_q.lvl  <= '0;
      res_q.code <= '0;
    end else if (req) begin
      res_q <= res_in;
    end
  end

  always_ff @(posedge clk) begin
    if (req) begin
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/dbg_rx_mailbox.sv
module dbg_rx_mailbox
  import dbg_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_vld,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              rd_req,
  input  logic [1:0]        cur_lvl,
  input  logic              l2_en,
  input  logic              l3_have,
  input  logic              l1_is32,
  input  logic              l2_is32,
  input  logic              l3_is32,
  input  logic              l1_chan_trap,
  input  logic              l1_chan_dis,
  input  logic              l2_route_all,
  input  logic              l2_dbg_exc_trap,
  input  logic              l2_dbg_acc_trap,
  input  logic              l3_dbg_acc_trap,
  output logic              full,
  output logic              rsp_vld,
  output logic [1:0]        rsp_kind,
  output logic [1:0]        rsp_lvl,
  output logic [5:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_data
);

  gate_cfg_t         cfg;
  gate_res_t         gate_res;
  gate_res_t         rsp_res;
  logic [DATA_W-1:0] word_q;
  logic              rd_clear;

  always_comb begin
    cfg.l2_en           = l2_en;
    cfg.l3_have         = l3_have;
    cfg.l1_is32         = l1_is32;
    cfg.l2_is32         = l2_is32;
    cfg.l3_is32         = l3_is32;
    cfg.l1_chan_trap    = l1_chan_trap;
    cfg.l1_chan_dis     = l1_chan_dis;
    cfg.l2_route_all    = l2_route_all;
    cfg.l2_dbg_exc_trap = l2_dbg_exc_trap;
    cfg.l2_dbg_acc_trap = l2_dbg_acc_trap;
    cfg.l3_dbg_acc_trap = l3_dbg_acc_trap;
  end

  dbg_rx_gate u_gate (
    .cur_lvl (cur_lvl),
    .cfg     (cfg),
    .res     (gate_res)
  );

  assign rd_clear = rd_req && (gate_res.kind == RSP_DATA);

  dbg_rx_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vld   (host_wr_vld),
    .wr_data  (host_wr_data),
    .rd_clear (rd_clear),
    .data_q   (word_q),
    .full_q   (full)
  );

  dbg_rx_resp #(.DATA_W(DATA_W)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (rd_req),
    .res_in  (gate_res),
    .word_in (word_q),
    .vld_q   (rsp_vld),
    .res_q   (rsp_res),
    .data_q  (rsp_data)
  );

  assign rsp_kind = rsp_res.kind;
  assign rsp_lvl  = rsp_res.lvl;
  assign rsp_code = rsp_res.code;

endmodule

// File: rtl/dbg_rx_mailbox_chk.sv
module dbg_rx_mailbox_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_vld,
  input logic              rd_req,
  input logic [1:0]        cur_lvl,
  input logic              full,
  input logic              rsp_vld,
  input logic [1:0]        rsp_kind,
  input logic [1:0]        rsp_lvl,
  input logic [DATA_W-1:0] rsp_data
);

  p_rsp_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_vld);

  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_vld);

  p_write_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_vld |=> full);

  p_data_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_kind == 2'd0 && !$past(host_wr_vld)) |-> !full);

  p_trap_keeps_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_kind != 2'd0 && $past(full)) |-> full);

  p_trap_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_kind != 2'd0) |-> (rsp_data == '0));

  p_top_level_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cur_lvl == 2'd3) |=> (rsp_kind == 2'd0 && rsp_lvl == 2'd3));

  p_hyp_to_level2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_kind == 2'd2) |-> (rsp_lvl == 2'd2));

endmodule

bind dbg_rx_mailbox dbg_rx_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_wr_vld (host_wr_vld),
  .rd_req      (rd_req),
  .cur_lvl     (cur_lvl),
  .full        (full),
  .rsp_vld     (rsp_vld),
  .rsp_kind    (rsp_kind),
  .rsp_lvl     (rsp_lvl),
  .rsp_data    (rsp_data)
);

// File: tb/dbg_rx_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_rx_mailbox_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_vld;
  logic [31:0] host_wr_data;
  logic        rd_req;
  logic [1:0]  cur_lvl;
  logic [10:0] cfgv;
  logic        full;
  logic        rsp_vld;
  logic [1:0]  rsp_kind;
  logic [1:0]  rsp_lvl;
  logic [5:0]  rsp_code;
  logic [31:0] rsp_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  // cfgv bit map: 10 l2_en, 9 l3_have, 8 l1_is32, 7 l2_is32, 6 l3_is32,
  // 5 l1_chan_trap, 4 l1_chan_dis, 3 l2_route_all, 2 l2_dbg_exc_trap,
  // 1 l2_dbg_acc_trap, 0 l3_dbg_acc_trap
  dbg_rx_mailbox u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_wr_vld     (host_wr_vld),
    .host_wr_data    (host_wr_data),
    .rd_req          (rd_req),
    .cur_lvl         (cur_lvl),
    .l2_en           (cfgv[10]),
    .l3_have         (cfgv[9]),
    .l1_is32         (cfgv[8]),
    .l2_is32         (cfgv[7]),
    .l3_is32         (cfgv[6]),
    .l1_chan_trap    (cfgv[5]),
    .l1_chan_dis     (cfgv[4]),
    .l2_route_all    (cfgv[3]),
    .l2_dbg_exc_trap (cfgv[2]),
    .l2_dbg_acc_trap (cfgv[1]),
    .l3_dbg_acc_trap (cfgv[0]),
    .full            (full),
    .rsp_vld         (rsp_vld),
    .rsp_kind        (rsp_kind),
    .rsp_lvl         (rsp_lvl),
    .rsp_code        (rsp_code),
    .rsp_data        (rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {kind, level, code} from requirements R5..R9, R11.
  function automatic logic [9:0] expect_rsp(input logic [1:0] lv, input logic [10:0] c);
    logic e2, l3, a1, a2, a3, tr, ds, ra, te, ta, t3, l2_64, l2_32, l3_hit;
    {e2, l3, a1, a2, a3, tr, ds, ra, te, ta, t3} = c;
    l2_64  = e2 && !a2;
    l2_32  = e2 && a2;
    l3_hit = l3 && !a3 && t3;
    if (lv == 2'd3) return {2'd0, 2'd3, 6'h00};
    if (lv == 2'd0) begin
      if (!a1 && tr) return {2'd1, (l2_64 && ra) ? 2'd2 : 2'd1, 6'h05};
      if (a1 && ds) begin
        if (l2_64 && ra) return {2'd1, 2'd2, 6'h05};
        if (l2_32 && ra) return {2'd2, 2'd2, 6'h00};
        return {2'd3, 2'd1, 6'h00};
      end
      if (l2_64 && (ra || te || ta)) return {2'd1, 2'd2, 6'h05};
    end
    if (lv == 2'd1) begin
      if (l2_64 && (te || ta)) return {2'd1, 2'd2, 6'h05};
      if (l2_32 && (te || ta)) return {2'd2, 2'd2, 6'h05};
    end
    if (l3_hit) return {2'd1, 2'd3, 6'h05};
    return {2'd0, lv, 6'h00};
  endfunction

  task automatic host_write(input logic [31:0] d);
    @(negedge clk);
    host_wr_vld  = 1'b1;
    host_wr_data = d;
    @(negedge clk);
    host_wr_vld  = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] lv, input logic [10:0] c);
    @(negedge clk);
    rd_req  = 1'b1;
    cur_lvl = lv;
    cfgv    = c;
    @(negedge clk);
    rd_req  = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] pat;
    logic [9:0]  exp;
    rst_n = 1'b0; host_wr_vld = 1'b0; host_wr_data = '0;
    rd_req = 1'b0; cur_lvl = 2'd0; cfgv = '0;
    repeat (3) @(negedge clk);
    check("R1 full in reset", {31'd0, full}, 32'd0);
    check("R1 rsp_vld in reset", {31'd0, rsp_vld}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 full after reset", {31'd0, full}, 32'd0);
    check("R11 no rsp when idle", {31'd0, rsp_vld}, 32'd0);

    // R3: data read of empty mailbox leaves flag clear
    cpu_read(2'd3, '0);
    check("R11 rsp_vld after read", {31'd0, rsp_vld}, 32'd1);
    check("R3 empty read flag", {31'd0, full}, 32'd0);
    @(negedge clk);
    check("R11 rsp_vld drops", {31'd0, rsp_vld}, 32'd0);

    // R2: back-to-back writes, last wins
    host_write(32'h1111_2222);
    check("R2 full after write", {31'd0, full}, 32'd1);
    host_write(32'hCAFE_F00D);
    cpu_read(2'd2, '0);
    check("R2 last word", rsp_data, 32'hCAFE_F00D);
    check("R3 flag cleared", {31'd0, full}, 32'd0);

    // R4: collision of write and clearing read
    host_write(32'h0BAD_BEEF);
    @(negedge clk);
    rd_req = 1'b1; cur_lvl = 2'd3; cfgv = '0;
    host_wr_vld = 1'b1; host_wr_data = 32'h5EED_0001;
    @(negedge clk);
    rd_req = 1'b0; host_wr_vld = 1'b0;
    check("R4 old word returned", rsp_data, 32'h0BAD_BEEF);
    check("R4 full kept", {31'd0, full}, 32'd1);
    cpu_read(2'd3, '0);
    check("R4 new word next", rsp_data, 32'h5EED_0001);
    check("R4 cleared after", {31'd0, full}, 32'd0);

    // R5..R11 exhaustive sweep over level and all control settings
    for (int lv = 0; lv < 4; lv++) begin
      for (int c = 0; c < 2048; c++) begin
        pat = 32'hA500_0000 ^ (32'(lv * 2048 + c) * 32'h9E37_79B1);
        host_write(pat);
        cpu_read(lv[1:0], c[10:0]);
        exp = expect_rsp(lv[1:0], c[10:0]);
        check("R11 rsp_vld", {31'd0, rsp_vld}, 32'd1);
        check("R5-R9 kind R5 R6 R7 R8 R9", {30'd0, rsp_kind}, {30'd0, exp[9:8]});
        check("R5-R9 target level", {30'd0, rsp_lvl}, {30'd0, exp[7:6]});
        check("R5-R9 code", {26'd0, rsp_code}, {26'd0, exp[5:0]});
        if (exp[9:8] == 2'd0) begin
          check("R2 data", rsp_data, pat);
          check("R3 full cleared", {31'd0, full}, 32'd0);
        end else begin
          check("R10 no data", rsp_data, 32'd0);
          check("R10 full kept", {31'd0, full}, 32'd1);
        end
      end
    end

    finish_run();
  end

endmodule